// File: doc/BRIEF.md
# AIS and QRSS pattern detector

This block monitors the recovered receive bit stream of one T1/E1 port and drives a single pattern-detect output. It runs on a clock at twice the line bit rate. Each received bit arrives as one accepted transfer on a valid/ready input, so accepted bits occur at most once every two clock cycles. A static mode input chooses what the output reports.

In alarm mode the block counts zeros in consecutive fixed windows of 2048 received bits. A nearly all-ones window, which is the alarm indication signal, sets the output. A window with enough zeros clears it. In pseudo-random mode the block seeds a local reference generator from the incoming bits and tries to lock it to the line. While unlocked the output is held high. Once locked, the output is low except for a one-clock pulse after each errored bit, so an external counter can count bit errors. The zero counting runs in both modes; only the output selection changes. Loopback paths therefore have no influence on it.

The input never applies back-pressure. `bit_ready_o` is held high, and a bit is taken on every rising edge at which `bit_valid_i` is high. The source must leave at least one idle cycle between two valid cycles, so that each error pulse fills the second half of its bit period.

Top module: `pattern_detect`

## Requirements
- R1: In alarm mode (`mode_qrss_i`=0), at the end of a 2048-bit window with fewer than three zeros, `pd_o` is high from the clock after the window's last bit.
- R2: In alarm mode, a window with four or more zeros drives `pd_o` low after its last bit. A window with exactly three zeros leaves `pd_o` as it was. Between window ends `pd_o` does not change.
- R3: Windows are counted in accepted bits only and begin at reset. Cycles with `bit_valid_i` low are ignored whatever `bit_data_i` carries.
- R4: In pseudo-random mode (`mode_qrss_i`=1), `pd_o` is high whenever the checker is out of sync, and low in sync except for error pulses.
- R5: Out of sync, the reference is loaded with 20 received bits. A 128-bit trial comparison follows. Sync is declared after the trial's last bit if the trial, including that bit, held fewer than four mismatches. Otherwise seeding starts again.
- R6: In sync, each mismatching accepted bit makes `pd_o` high for exactly the one clock cycle after the edge that accepted it.
- R7: In sync, mismatches are counted in consecutive 128-bit windows. The 32nd mismatch within one window drops sync at once, so `pd_o` is high from the next cycle and seeding restarts. 31 mismatches in a window keep sync.
- R8: The reference is the sequence x[n] = x[n-20] XOR x[n-17]. Its output is forced to one wherever the raw sequence would give a 14th or later consecutive zero. The shift register keeps the raw bits.
- R9: Synchronous active-high `rst` clears the window and error counters, sets the alarm result low and puts the checker out of sync.
- R10: `bit_ready_o` is always high. `bit_valid_i` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the line bit rate |
| rst | input | 1 | Synchronous reset, active high |
| mode_qrss_i | input | 1 | Static mode: 0 alarm window, 1 pseudo-random checker |
| bit_valid_i | input | 1 | A received bit is present on bit_data_i |
| bit_ready_o | output | 1 | Always high; the block never stalls the stream |
| bit_data_i | input | 1 | Received bit value |
| pd_o | output | 1 | Pattern-detect output |

## Verification
Two events can land on the same accepted bit: a window boundary and an error decision. The 128-bit sync window can wrap on the very bit that brings the 32nd mismatch, and a trial can end on an errored bit whose count decides pass or fail. The bench places the 32nd flipped bit exactly on the last bit of a sync window and puts one flipped bit on the last trial bit in both a passing (three-error) and a failing (four-error) trial. A behavioural reference model judges every clock: loss must win over the window restart, and the final trial bit must be counted before the pass decision.

// File: rtl/pdet_pkg.sv
package pdet_pkg;
  typedef enum logic [1:0] {
    QS_SEED  = 2'd0,
    QS_TRIAL = 2'd1,
    QS_SYNC  = 2'd2
  } qstate_e;
endpackage

// File: rtl/pdet_ais_window.sv
module pdet_ais_window #(
  parameter int WIN_BITS  = 2048,
  parameter int ZERO_MARK = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_data,
  output logic alarm_o
);
  localparam int CW = $clog2(WIN_BITS);
  localparam int ZW = $clog2(ZERO_MARK + 3);
  localparam logic [CW-1:0] LAST = CW'(WIN_BITS - 1);
  localparam logic [ZW-1:0] ZM   = ZW'(ZERO_MARK);
  localparam logic [ZW-1:0] ZSAT = ZW'(ZERO_MARK + 1);

  logic [CW-1:0] wcnt;
  logic [ZW-1:0] zcnt;
  logic [ZW-1:0] ztot;

  // zeros so far including the bit now accepted
  assign ztot = zcnt + {{(ZW-1){1'b0}}, ~bit_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt    <= '0;
      zcnt    <= '0;
      alarm_o <= 1'b0;
    end else if (bit_en) begin
      if (wcnt == LAST) begin
        wcnt <= '0;
        zcnt <= '0;
        if (ztot < ZM)      alarm_o <= 1'b1;
        else if (ztot > ZM) alarm_o <= 1'b0;
      end else begin
        wcnt <= wcnt + 1'b1;
        zcnt <= (ztot > ZSAT) ? ZSAT : ztot;
      end
    end
  end
endmodule

// File: rtl/pdet_prbs_ref.sv
module pdet_prbs_ref #(
  parameter int LEN  = 20,
  parameter int TAP  = 17,
  parameter int ZRUN = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  input  logic load_i,
  input  logic load_bit_i,
  output logic pred_o
);
  localparam int ZW = $clog2(ZRUN);
  localparam logic [ZW-1:0] ZLIM = ZW'(ZRUN - 1);

  logic [LEN-1:0] sr;
  logic [ZW-1:0]  zrun;
  logic           raw;
  logic           in_bit;

  assign raw    = sr[LEN-1] ^ sr[TAP-1];
  // a raw zero after ZRUN-1 zeros is sent as a one
  assign pred_o = raw | (zrun == ZLIM);
  assign in_bit = load_i ? load_bit_i : raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      zrun <= '0;
    end else if (step_i) begin
      sr   <= {sr[LEN-2:0], in_bit};
      zrun <= in_bit ? '0 : ((zrun == ZLIM) ? ZLIM : zrun + 1'b1);
    end
  end
endmodule

// File: rtl/pdet_qrss_sync.sv
module pdet_qrss_sync
  import pdet_pkg::*;
#(
  parameter int SEED_BITS  = 20,
  parameter int WIN        = 128,
  parameter int PASS_LIMIT = 4,
  parameter int LOSS_LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_data,
  input  logic pred_i,
  output logic load_o,
  output logic in_sync_o,
  output logic err_pulse_o
);
  localparam int SPAN = (WIN > SEED_BITS) ? WIN : SEED_BITS;
  localparam int SW   = $clog2(SPAN);
  localparam int EW   = $clog2(WIN + 1);
  localparam logic [SW-1:0] SEED_LAST = SW'(SEED_BITS - 1);
  localparam logic [SW-1:0] WIN_LAST  = SW'(WIN - 1);
  localparam logic [EW:0]   PASS_L    = (EW+1)'(PASS_LIMIT);
  localparam logic [EW:0]   LOSS_L    = (EW+1)'(LOSS_LIMIT);

  qstate_e       state_q;
  logic [SW-1:0] cnt;
  logic [EW-1:0] ecnt;
  logic [EW:0]   esum;
  logic          err;

  assign err         = bit_data ^ pred_i;
  assign esum        = {1'b0, ecnt} + {{EW{1'b0}}, err};
  assign load_o      = (state_q == QS_SEED);
  assign in_sync_o   = (state_q == QS_SYNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= QS_SEED;
      cnt         <= '0;
      ecnt        <= '0;
      err_pulse_o <= 1'b0;
    end else begin
      err_pulse_o <= 1'b0;
      if (bit_en) begin
        unique case (state_q)
          QS_SEED: begin
            if (cnt == SEED_LAST) begin
              state_q <= QS_TRIAL;
              cnt     <= '0;
              ecnt    <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          QS_TRIAL: begin
            if (cnt == WIN_LAST) begin
              state_q <= (esum < PASS_L) ? QS_SYNC : QS_SEED;
              cnt     <= '0;
              ecnt    <= '0;
            end else begin
              cnt  <= cnt + 1'b1;
              ecnt <= esum[EW-1:0];
            end
          end
          QS_SYNC: begin
            err_pulse_o <= err;
            if (esum >= LOSS_L) begin
              state_q <= QS_SEED;
              cnt     <= '0;
              ecnt    <= '0;
            end else if (cnt == WIN_LAST) begin
              cnt  <= '0;
              ecnt <= '0;
            end else begin
              cnt  <= cnt + 1'b1;
              ecnt <= esum[EW-1:0];
            end
          end
          default: state_q <= QS_SEED;
        endcase
      end
    end
  end
endmodule

// File: rtl/pattern_detect.sv
module pattern_detect #(
  parameter int WIN_BITS   = 2048,
  parameter int ZERO_MARK  = 3,
  parameter int PRBS_LEN   = 20,
  parameter int PRBS_TAP   = 17,
  parameter int ZERO_RUN   = 14,
  parameter int SYNC_WIN   = 128,
  parameter int PASS_LIMIT = 4,
  parameter int LOSS_LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_qrss_i,
  input  logic bit_valid_i,
  output logic bit_ready_o,
  input  logic bit_data_i,
  output logic pd_o
);
  logic bit_en;
  logic alarm_w;
  logic load_w;
  logic pred_w;
  logic sync_w;
  logic pulse_w;

  assign bit_ready_o = 1'b1;
  assign bit_en      = bit_valid_i & bit_ready_o;

  pdet_ais_window #(.WIN_BITS(WIN_BITS), .ZERO_MARK(ZERO_MARK)) u_ais (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_data(bit_data_i),
    .alarm_o(alarm_w)
  );

  pdet_prbs_ref #(.LEN(PRBS_LEN), .TAP(PRBS_TAP), .ZRUN(ZERO_RUN)) u_ref (
    .clk(clk), .rst(rst), .step_i(bit_en), .load_i(load_w),
    .load_bit_i(bit_data_i), .pred_o(pred_w)
  );

  pdet_qrss_sync #(.SEED_BITS(PRBS_LEN), .WIN(SYNC_WIN),
                   .PASS_LIMIT(PASS_LIMIT), .LOSS_LIMIT(LOSS_LIMIT)) u_sync (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_data(bit_data_i),
    .pred_i(pred_w), .load_o(load_w), .in_sync_o(sync_w),
    .err_pulse_o(pulse_w)
  );

  assign pd_o = mode_qrss_i ? (~sync_w | pulse_w) : alarm_w;
endmodule

// File: rtl/pdet_checker.sv
module pdet_checker #(
  parameter int WIN_BITS = 2048
) (
  input logic clk,
  input logic rst,
  input logic mode,
  input logic valid,
  input logic pd,
  input logic in_sync
);
  localparam int CW = $clog2(WIN_BITS);
  logic [CW-1:0] wpos;

  always_ff @(posedge clk) begin
    if (rst)        wpos <= '0;
    else if (valid) wpos <= (wpos == CW'(WIN_BITS - 1)) ? '0 : wpos + 1'b1;
  end

  // R4: unlocked checker holds the output high
  p_unsync_high_r4: assert property (@(posedge clk) disable iff (rst)
    (mode && !in_sync) |-> pd);

  // R6: an error pulse lasts one cycle
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    (mode && in_sync && pd) |=> (!pd || !in_sync));

  // R6: a pulse follows an accepted bit
  p_pulse_after_bit_r6: assert property (@(posedge clk) disable iff (rst)
    (mode && in_sync && pd) |-> $past(valid));

  // R2: alarm result moves only at a window's last bit
  p_ais_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!mode && !(valid && wpos == CW'(WIN_BITS - 1))) |=> $stable(pd));

  // R9: reset leaves the checker out of sync
  p_reset_unsync_r9: assert property (@(posedge clk)
    rst |=> !in_sync);

  // R10: accepted bits are spaced by at least one idle cycle
  p_spacing_r10: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
endmodule

bind pattern_detect pdet_checker #(.WIN_BITS(WIN_BITS)) chk_i (
  .clk(clk), .rst(rst), .mode(mode_qrss_i), .valid(bit_valid_i),
  .pd(pd_o), .in_sync(sync_w)
);

// File: tb/pattern_detect_tb_top.sv
module pattern_detect_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0;
  logic valid = 1'b0;
  logic data = 1'b0;
  logic ready;
  logic pd;

  always #4 clk = ~clk;

  pattern_detect dut_i (
    .clk(clk), .rst(rst), .mode_qrss_i(mode), .bit_valid_i(valid),
    .bit_ready_o(ready), .bit_data_i(data), .pd_o(pd)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R9";
  bit seen_pd = 1'b0;

  // ---------------- reference model ----------------
  int m_w, m_z, m_ph, m_cnt, m_ecnt, m_zrun;
  bit m_alarm, m_errq;
  bit m_h[$];

  always @(posedge clk) begin
    if (rst) begin
      m_w = 0; m_z = 0; m_alarm = 0; m_ph = 0; m_cnt = 0; m_ecnt = 0;
      m_errq = 0; m_zrun = 0;
      m_h.delete();
      repeat (20) m_h.push_back(1'b0);
    end else begin
      m_errq = 0;
      if (valid) begin
        bit raw, pred, err, nb;
        if (!data) m_z++;
        if (m_w == 2047) begin
          if (m_z < 3) m_alarm = 1;
          else if (m_z > 3) m_alarm = 0;
          m_w = 0; m_z = 0;
        end else m_w++;
        raw  = m_h[0] ^ m_h[3];
        pred = raw | (!raw && m_zrun >= 13);
        err  = (data != pred);
        nb   = (m_ph == 0) ? data : raw;
        void'(m_h.pop_front());
        m_h.push_back(nb);
        m_zrun = nb ? 0 : m_zrun + 1;
        case (m_ph)
          0: if (m_cnt == 19) begin m_ph = 1; m_cnt = 0; m_ecnt = 0; end
             else m_cnt++;
          1: begin
            m_ecnt += err;
            if (m_cnt == 127) begin
              m_ph = (m_ecnt < 4) ? 2 : 0; m_cnt = 0; m_ecnt = 0;
            end else m_cnt++;
          end
          default: begin
            m_errq = err;
            m_ecnt += err;
            if (m_ecnt >= 32) begin m_ph = 0; m_cnt = 0; m_ecnt = 0; end
            else if (m_cnt == 127) begin m_cnt = 0; m_ecnt = 0; end
            else m_cnt++;
          end
        endcase
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit exp_pd;
      exp_pd = mode ? ((m_ph != 2) || m_errq) : m_alarm;
      if (pd) seen_pd = 1'b1;
      checks++;
      if (pd !== exp_pd) begin
        fails++;
        $display("FAIL %s per-cycle pd_o=%0b expected=%0b at %0t", cur_req, pd, exp_pd, $time);
      end
      checks++;
      if (ready !== 1'b1) begin
        fails++;
        $display("FAIL R10 bit_ready_o=%0b expected=1", ready);
      end
    end
  end

  task automatic chk(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s pd_o=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  // idle cycles carry a zero on the data pin to show they are ignored (R3)
  task automatic send_bit(input bit b, input int idle);
    repeat (idle) begin
      @(posedge clk); #2; valid = 1'b0; data = 1'b0;
    end
    @(posedge clk); #2; valid = 1'b1; data = b;
    @(posedge clk); #2; valid = 1'b0; data = 1'b0;
  endtask

  task automatic do_reset(input bit m, input string req);
    @(posedge clk); #2; rst = 1'b1; mode = m; valid = 1'b0;
    repeat (3) @(posedge clk);
    #2; rst = 1'b0;
    cur_req = req;
  endtask

  // ---------------- stimulus sources ----------------
  task automatic ais_win(input int nz);
    for (int i = 0; i < 2048; i++) begin
      bit b;
      b = !((i % 100 == 7) && (i / 100 < nz));
      send_bit(b, (i % 7 == 3) ? 1 : 0);
    end
  endtask

  bit t_h[$];
  int t_z;
  int t_forced;

  // place the state so the longest zero run of the sequence arrives at bits 281..299
  task automatic tx_init();
    t_h.delete();
    t_h.push_back(1'b1);
    repeat (19) t_h.push_back(1'b0);
    repeat (300) begin
      bit p;
      p = t_h[19] ^ t_h[2];
      void'(t_h.pop_back());
      t_h.push_front(p);
    end
    t_z = 0;
    t_forced = 0;
  endtask

  function automatic bit tx_next();
    bit raw, o;
    raw = t_h[0] ^ t_h[3];
    o = raw | (!raw && t_z >= 13);
    if (o && !raw) t_forced++;
    void'(t_h.pop_front());
    t_h.push_back(raw);
    t_z = raw ? 0 : t_z + 1;
    return o;
  endfunction

  task automatic run_tx(input int n, input int errs[$]);
    for (int i = 0; i < n; i++) begin
      bit b;
      b = tx_next();
      foreach (errs[k]) if (errs[k] == i) b = ~b;
      send_bit(b, (i % 5 == 4) ? 1 : 0);
    end
  endtask

  int none[$];
  int e1[$];
  int e2[$];

  initial begin
    // ---------- alarm mode ----------
    do_reset(1'b0, "R9");
    #1 chk(pd, 1'b0, "R9 reset");
    cur_req = "R1";
    ais_win(0);   chk(pd, 1'b1, "R1 all-ones window");
    cur_req = "R2";
    ais_win(3);   chk(pd, 1'b1, "R2 three zeros hold high");
    ais_win(4);   chk(pd, 1'b0, "R2 four zeros clear");
    ais_win(3);   chk(pd, 1'b0, "R2 three zeros hold low");
    cur_req = "R3";
    ais_win(2);   chk(pd, 1'b1, "R3 window aligned, two zeros set");

    // ---------- pseudo-random mode, main run ----------
    do_reset(1'b1, "R4");
    tx_init();
    #1 chk(pd, 1'b1, "R4 out of sync after reset");
    cur_req = "R5";
    run_tx(148, none); chk(pd, 1'b0, "R5 sync after seed and trial");
    cur_req = "R7";
    e1.delete();
    for (int k = 1; k <= 31; k++) e1.push_back(2 * k);
    run_tx(128, e1); chk(pd, 1'b0, "R7 31 errors keep sync");
    e2.delete();
    for (int k = 0; k < 31; k++) e2.push_back(2 * k);
    e2.push_back(127);
    run_tx(128, e2); chk(pd, 1'b1, "R7 32nd error on window last bit");
    cur_req = "R4";
    run_tx(148, none); chk(pd, 1'b0, "R4 resync after loss");
    cur_req = "R6";
    run_tx(1, '{0});
    chk(pd, 1'b1, "R6 pulse in errored half bit");
    @(posedge clk); #2;
    chk(pd, 1'b0, "R6 pulse one cycle only");
    run_tx(60, '{3, 17, 40});
    chk(pd, 1'b0, "R6 sync kept after sparse errors");

    // ---------- trial boundary ----------
    do_reset(1'b1, "R5");
    tx_init();
    run_tx(20, none);
    run_tx(128, '{0, 60, 127}); chk(pd, 1'b0, "R5 three trial errors pass");
    do_reset(1'b1, "R5");
    tx_init();
    run_tx(20, none);
    run_tx(128, '{0, 60, 90, 127}); chk(pd, 1'b1, "R5 four trial errors fail");
    run_tx(148, none); chk(pd, 1'b0, "R5 reseed then sync");

    // ---------- zero suppression ----------
    do_reset(1'b1, "R8");
    tx_init();
    run_tx(148, none); chk(pd, 1'b0, "R8 sync before zero run");
    seen_pd = 1'b0;
    run_tx(200, none);
    chk(seen_pd, 1'b0, "R8 no error through suppressed zero run");
    checks++;
    if (t_forced == 0) begin
      fails++;
      $display("FAIL R8 forced ones=%0d expected>0", t_forced);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule